// File: doc/BRIEF.md
# Adaptive Two-Arm Phase Controller

This block sequences the signal phases of a two-arm road crossing. It holds a queued-car count for each arm, raised by an entry-sensor strobe and lowered by an exit-sensor strobe. It also keeps a timer of the ticks spent in the current phase. On every time-base tick it decides whether the current phase ends. The green phase of the arm being served ends on a demand function that weighs both queues. Minimum and maximum durations bound that decision, and a stall detector forces a change when the served queue stops moving.

The phase order is green, yellow, protected left turn, yellow, then the green of the other arm. A pedestrian request, once latched, inserts a walk phase after the left-turn yellow and before the other arm's green. Each change of phase raises a one-cycle switch strobe. The strobe appears together with the new phase code and the index of the arm being served. Weights, offsets and duration limits are static configuration inputs. Lamp decoding is done elsewhere.

Top module: `adaptive_phase_ctrl`

## Requirements
- R1: A one-cycle `entry_i[k]` strobe increments queue k and an `exit_i[k]` strobe decrements it. Both strobes together leave the count unchanged, and a count moves by at most one per cycle.
- R2: A queue count saturates: a decrement at 0 keeps 0, and an increment at 2^CW-1 keeps 2^CW-1.
- R3: After reset the phase is green (`phase_o`=0), the served arm is `arm_o`=0 (the first arm), `switch_o` is low and both counts are 0.
- R4: The elapsed count at a tick is the number of ticks in the phase, including that tick. A green phase never ends while the elapsed count is below `gmin_i[arm]`.
- R5: A green phase ends on the tick where the elapsed count reaches `gmax_i[arm]`.
- R6: Between the two bounds, a green phase ends when the served queue is 0 or when f = alpha·n_served + beta − n_other ≤ 0. alpha and beta are the signed 8-bit values of the served arm, and f is evaluated without overflow.
- R7: In green or left phase, once the minimum is met, the phase ends on the 5th consecutive tick in which the served queue has not changed.
- R8: Yellow (`phase_o`=1) lasts exactly 2 ticks. It always follows green or left. After a green it leads to left (`phase_o`=2) for the same arm.
- R9: A left phase never ends below `lmin_i` and always ends when the elapsed count reaches `lmax_i`.
- R10: A `ped_req_i` strobe is latched. After the left-turn yellow, a pending request enters walk (`phase_o`=3) for `walk_i` ticks and is cleared. Without a request, the yellow leads straight on. Both walk and the no-request yellow lead to green of the other arm (`arm_o` toggles).
- R11: `switch_o` is high for exactly the cycle after the tick edge that changes phase. It is high only after a tick, and `phase_o` changes exactly when `switch_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_i | input | 1 | Time-base strobe, one cycle per time unit |
| entry_i | input | 2 | Car-arrival strobes, bit k for arm k |
| exit_i | input | 2 | Car-departure strobes, bit k for arm k |
| ped_req_i | input | 1 | Pedestrian request strobe |
| alpha_i | input | 2x8 | Signed queue weight per arm |
| beta_i | input | 2x8 | Signed offset per arm |
| gmin_i | input | 2xTW | Minimum green ticks per arm |
| gmax_i | input | 2xTW | Maximum green ticks per arm |
| lmin_i | input | TW | Minimum left-turn ticks |
| lmax_i | input | TW | Maximum left-turn ticks |
| walk_i | input | TW | Walk phase ticks |
| phase_o | output | 2 | Phase code: 0 green, 1 yellow, 2 left, 3 walk |
| arm_o | output | 1 | Index of the arm being served |
| switch_o | output | 1 | One-cycle strobe on every phase change |
| queue_o | output | 2xCW | Queued-car count per arm |

## Verification
The bench targets the off-by-one edges of every bound. It checks that no switch happens on the tick before a minimum and that a switch does happen on the tick that reaches a maximum. It drives f to exactly 0 and to +1. A design that compared with `<` instead of `≤` would hold at f = 0. It counts five unchanged ticks for the stall rule, where a design that reset or checked late would switch one tick off. Queue tests drive simultaneous strobes and both saturation ends; a wrapping counter would jump between 0 and full. The phase-order tests run with and without a walk request, which shows a lost request, a walk placed at the wrong point, or an arm that fails to toggle.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  typedef enum logic [1:0] {
    PH_GREEN  = 2'd0,
    PH_YELLOW = 2'd1,
    PH_LEFT   = 2'd2,
    PH_WALK   = 2'd3
  } phase_e;

  localparam int unsigned YELLOW_TICKS = 2;
  localparam int unsigned STALL_TICKS  = 5;
  localparam int unsigned WEIGHT_W     = 8;
endpackage

// File: rtl/tpc_queue.sv
module tpc_queue #(
  parameter int unsigned CW = 6
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [CW-1:0] cnt_o,
  output logic          chg_o
);
  localparam logic [CW-1:0] QMAX = {CW{1'b1}};

  logic [CW-1:0] cnt_q, cnt_d;
  logic          up, dn;

  always_comb begin
    up    = inc_i & ~dec_i & (cnt_q != QMAX);
    dn    = dec_i & ~inc_i & (cnt_q != '0);
    cnt_d = cnt_q;
    if (up)      cnt_d = cnt_q + 1'b1;
    else if (dn) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (up || dn)  cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
  assign chg_o = up | dn;
endmodule

// File: rtl/tpc_demand.sv
module tpc_demand #(
  parameter int unsigned CW = 6,
  parameter int unsigned WW = 8
) (
  input  logic signed [WW-1:0] alpha_i,
  input  logic signed [WW-1:0] beta_i,
  input  logic        [CW-1:0] n_own_i,
  input  logic        [CW-1:0] n_oth_i,
  output logic                 f_le0_o,
  output logic                 own_zero_o
);
  localparam int unsigned FW = WW + CW + 3;

  logic signed [FW-1:0] own_s, oth_s, alp_s, bet_s, prod, f_val;

  always_comb begin
    own_s   = $signed({{(FW-CW){1'b0}}, n_own_i});
    oth_s   = $signed({{(FW-CW){1'b0}}, n_oth_i});
    alp_s   = $signed({{(FW-WW){alpha_i[WW-1]}}, alpha_i});
    bet_s   = $signed({{(FW-WW){beta_i[WW-1]}}, beta_i});
    prod    = alp_s * own_s;
    f_val   = prod + bet_s - oth_s;
    f_le0_o = f_val[FW-1] | (f_val == '0);
  end

  assign own_zero_o = (n_own_i == '0);
endmodule

// File: rtl/tpc_phase_fsm.sv
module tpc_phase_fsm
  import tpc_pkg::*;
#(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          ped_req_i,
  input  logic [1:0]    chg_i,
  input  logic [1:0]    zero_i,
  input  logic [1:0]    fle0_i,
  input  logic [1:0][TW-1:0] gmin_i,
  input  logic [1:0][TW-1:0] gmax_i,
  input  logic [TW-1:0] lmin_i,
  input  logic [TW-1:0] lmax_i,
  input  logic [TW-1:0] walk_i,
  output phase_e        phase_o,
  output logic          arm_o,
  output logic          switch_o
);
  localparam int unsigned SW = $clog2(STALL_TICKS + 1);
  localparam logic [TW-1:0] TMAX = {TW{1'b1}};
  localparam logic [SW-1:0] SMAX = {SW{1'b1}};
  localparam logic [SW-1:0] STALL_LIM = SW'(STALL_TICKS);
  localparam logic [TW-1:0] YEL_LIM   = TW'(YELLOW_TICKS);

  phase_e        phase_q, phase_d;
  logic          arm_q, arm_d;
  logic          after_left_q, after_left_d;
  logic          walk_pend_q, walk_pend_d;
  logic [TW-1:0] t_q, t_d, t_inc;
  logic [SW-1:0] stall_q, stall_d, stall_inc;
  logic          sw_q;
  logic          fav_chg, stall_hit, go, adv;

  always_comb begin
    t_inc     = (t_q == TMAX) ? t_q : t_q + 1'b1;
    stall_inc = (stall_q == SMAX) ? stall_q : stall_q + 1'b1;
    fav_chg   = chg_i[arm_q];
    stall_hit = !fav_chg && (stall_inc >= STALL_LIM);
    go        = 1'b0;
    unique case (phase_q)
      PH_GREEN:  go = (t_inc >= gmin_i[arm_q]) &&
                      ((t_inc >= gmax_i[arm_q]) || zero_i[arm_q] ||
                       fle0_i[arm_q] || stall_hit);
      PH_LEFT:   go = (t_inc >= lmin_i) && ((t_inc >= lmax_i) || stall_hit);
      PH_YELLOW: go = (t_inc >= YEL_LIM);
      PH_WALK:   go = (t_inc >= walk_i);
      default:   go = 1'b0;
    endcase
    adv = tick_i && go;
  end

  always_comb begin
    phase_d      = phase_q;
    arm_d        = arm_q;
    after_left_d = after_left_q;
    walk_pend_d  = walk_pend_q | ped_req_i;
    if (adv) begin
      unique case (phase_q)
        PH_GREEN: begin
          phase_d      = PH_YELLOW;
          after_left_d = 1'b0;
        end
        PH_LEFT: begin
          phase_d      = PH_YELLOW;
          after_left_d = 1'b1;
        end
        PH_YELLOW: begin
          if (!after_left_q) begin
            phase_d = PH_LEFT;
          end else if (walk_pend_q || ped_req_i) begin
            phase_d     = PH_WALK;
            walk_pend_d = 1'b0;
          end else begin
            phase_d = PH_GREEN;
            arm_d   = ~arm_q;
          end
        end
        PH_WALK: begin
          phase_d = PH_GREEN;
          arm_d   = ~arm_q;
        end
        default: phase_d = PH_GREEN;
      endcase
    end
  end

  always_comb begin
    t_d = t_q;
    if (adv)         t_d = '0;
    else if (tick_i) t_d = t_inc;
    stall_d = stall_q;
    if (adv || fav_chg) stall_d = '0;
    else if (tick_i)    stall_d = stall_inc;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q      <= PH_GREEN;
      arm_q        <= 1'b0;
      after_left_q <= 1'b0;
      walk_pend_q  <= 1'b0;
      t_q          <= '0;
      stall_q      <= '0;
      sw_q         <= 1'b0;
    end else begin
      phase_q      <= phase_d;
      arm_q        <= arm_d;
      after_left_q <= after_left_d;
      walk_pend_q  <= walk_pend_d;
      t_q          <= t_d;
      stall_q      <= stall_d;
      sw_q         <= adv;
    end
  end

  assign phase_o  = phase_q;
  assign arm_o    = arm_q;
  assign switch_o = sw_q;
endmodule

// File: rtl/adaptive_phase_ctrl.sv
module adaptive_phase_ctrl
  import tpc_pkg::*;
#(
  parameter int unsigned CW = 6,
  parameter int unsigned TW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic [1:0]          entry_i,
  input  logic [1:0]          exit_i,
  input  logic                ped_req_i,
  input  logic [1:0][7:0]     alpha_i,
  input  logic [1:0][7:0]     beta_i,
  input  logic [1:0][TW-1:0]  gmin_i,
  input  logic [1:0][TW-1:0]  gmax_i,
  input  logic [TW-1:0]       lmin_i,
  input  logic [TW-1:0]       lmax_i,
  input  logic [TW-1:0]       walk_i,
  output logic [1:0]          phase_o,
  output logic                arm_o,
  output logic                switch_o,
  output logic [1:0][CW-1:0]  queue_o
);
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  logic [1:0] chg, zero, fle0;
  phase_e     phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  for (genvar k = 0; k < 2; k++) begin : g_arm
    tpc_queue #(.CW(CW)) u_queue (
      .clk    (clk),
      .rst_ni (rst_ni),
      .inc_i  (entry_i[k]),
      .dec_i  (exit_i[k]),
      .cnt_o  (queue_o[k]),
      .chg_o  (chg[k])
    );
  end

  for (genvar k = 0; k < 2; k++) begin : g_dem
    tpc_demand #(.CW(CW), .WW(WEIGHT_W)) u_demand (
      .alpha_i    (alpha_i[k]),
      .beta_i     (beta_i[k]),
      .n_own_i    (queue_o[k]),
      .n_oth_i    (queue_o[1-k]),
      .f_le0_o    (fle0[k]),
      .own_zero_o (zero[k])
    );
  end

  tpc_phase_fsm #(.TW(TW)) u_fsm (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .ped_req_i (ped_req_i),
    .chg_i     (chg),
    .zero_i    (zero),
    .fle0_i    (fle0),
    .gmin_i    (gmin_i),
    .gmax_i    (gmax_i),
    .lmin_i    (lmin_i),
    .lmax_i    (lmax_i),
    .walk_i    (walk_i),
    .phase_o   (phase),
    .arm_o     (arm_o),
    .switch_o  (switch_o)
  );

  assign phase_o = phase;
endmodule

// File: rtl/tpc_checker.sv
module tpc_checker #(
  parameter int unsigned CW = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick_i,
  input logic [1:0]         entry_i,
  input logic [1:0]         exit_i,
  input logic [1:0]         phase_o,
  input logic               switch_o,
  input logic [1:0][CW-1:0] queue_o
);
  localparam logic [CW-1:0] QMAX = {CW{1'b1}};

  assert_switch_after_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    switch_o |-> $past(tick_i));

  assert_phase_moves_R11: assert property (@(posedge clk) disable iff (!rst_n)
    switch_o |-> (phase_o != $past(phase_o)));

  assert_phase_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !switch_o |-> $stable(phase_o));

  assert_yellow_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (switch_o && phase_o == 2'd1) |-> ($past(phase_o) == 2'd0 || $past(phase_o) == 2'd2));

  for (genvar k = 0; k < 2; k++) begin : g_q
    assert_queue_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (queue_o[k] != $past(queue_o[k])) |-> ($past(entry_i[k]) ^ $past(exit_i[k])));

    assert_queue_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (queue_o[k] == QMAX) |=> (queue_o[k] != '0));

    assert_queue_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (queue_o[k] == '0) |=> (queue_o[k] != QMAX));
  end
endmodule

bind adaptive_phase_ctrl tpc_checker #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_i   (tick_i),
  .entry_i  (entry_i),
  .exit_i   (exit_i),
  .phase_o  (phase_o),
  .switch_o (switch_o),
  .queue_o  (queue_o)
);

// File: tb/tb_adaptive_phase_ctrl.sv
module tb_adaptive_phase_ctrl;
  localparam int CW = 6;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic tick_i;
  logic [1:0] entry_i, exit_i;
  logic ped_req_i;
  logic [1:0][7:0] alpha_i, beta_i;
  logic [1:0][TW-1:0] gmin_i, gmax_i;
  logic [TW-1:0] lmin_i, lmax_i, walk_i;
  logic [1:0] phase_o;
  logic arm_o, switch_o;
  logic [1:0][CW-1:0] queue_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  adaptive_phase_ctrl #(.CW(CW), .TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .entry_i(entry_i), .exit_i(exit_i),
    .ped_req_i(ped_req_i), .alpha_i(alpha_i), .beta_i(beta_i), .gmin_i(gmin_i),
    .gmax_i(gmax_i), .lmin_i(lmin_i), .lmax_i(lmax_i), .walk_i(walk_i),
    .phase_o(phase_o), .arm_o(arm_o), .switch_o(switch_o), .queue_o(queue_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    tick_i = 0; entry_i = 0; exit_i = 0; ped_req_i = 0;
    alpha_i = '{8'sd1, 8'sd1}; beta_i = '0;
    gmin_i = '{8'd1, 8'd1}; gmax_i = '{8'd30, 8'd30};
    lmin_i = 8'd1; lmax_i = 8'd30; walk_i = 8'd3;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic tick();
    tick_i = 1;
    @(negedge clk);
    tick_i = 0;
  endtask

  task automatic pulse(input logic [1:0] ent, input logic [1:0] ext);
    entry_i = ent; exit_i = ext;
    @(negedge clk);
    entry_i = 0; exit_i = 0;
  endtask

  // tick n-1 times expecting hold, then tick once expecting switch to exp_ph
  task automatic run_phase(input int n, input int exp_ph, input string req);
    int start = phase_o;
    for (int i = 1; i < n; i++) begin
      tick();
      chk(!switch_o && phase_o == start, req, phase_o, start);
    end
    tick();
    chk(switch_o && phase_o == exp_ph, req, phase_o, exp_ph);
    @(negedge clk);
    chk(!switch_o, {req, "/R11 pulse width"}, switch_o, 0);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(phase_o == 0 && arm_o == 0, "R3 phase/arm", {phase_o, arm_o}, 0);
    chk(!switch_o, "R3 switch", switch_o, 0);
    chk(queue_o[0] == 0 && queue_o[1] == 0, "R3 queues", queue_o, 0);
  endtask

  task automatic t_queue();
    do_reset();
    repeat (3) pulse(2'b01, 2'b00);
    chk(queue_o[0] == 3, "R1 increment", queue_o[0], 3);
    pulse(2'b01, 2'b01);
    chk(queue_o[0] == 3, "R1 simultaneous", queue_o[0], 3);
    pulse(2'b10, 2'b00);
    chk(queue_o[1] == 1 && queue_o[0] == 3, "R1 arm independence", queue_o[1], 1);
    repeat (4) pulse(2'b00, 2'b01);
    chk(queue_o[0] == 0, "R2 floor", queue_o[0], 0);
    repeat (65) pulse(2'b01, 2'b00);
    chk(queue_o[0] == 63, "R2 ceiling", queue_o[0], 63);
  endtask

  task automatic t_min_hold();
    do_reset();
    gmin_i[0] = 8'd3;
    run_phase(3, 1, "R4 min hold");
  endtask

  task automatic t_max_end();
    do_reset();
    beta_i[0] = 8'sd2; gmax_i[0] = 8'd3;
    repeat (5) pulse(2'b01, 2'b00);
    run_phase(3, 1, "R5 max end");
  endtask

  task automatic t_demand();
    do_reset();
    gmin_i[0] = 8'd2;
    repeat (3) pulse(2'b01, 2'b00);
    repeat (10) pulse(2'b10, 2'b00);
    run_phase(2, 1, "R6 f negative");
    do_reset();
    gmin_i[0] = 8'd2; beta_i[0] = 8'sd2;
    repeat (3) pulse(2'b01, 2'b00);
    repeat (5) pulse(2'b10, 2'b00);
    run_phase(2, 1, "R6 f zero");
    do_reset();
    gmin_i[0] = 8'd2; beta_i[0] = 8'sd3;
    repeat (3) pulse(2'b01, 2'b00);
    repeat (5) pulse(2'b10, 2'b00);
    run_phase(5, 1, "R6 f one holds, R7 stall");
    do_reset();
    alpha_i[0] = -8'sd4; beta_i[0] = 8'sd127; gmin_i[0] = 8'd2;
    repeat (40) pulse(2'b01, 2'b00);
    run_phase(2, 1, "R6 negative weight");
  endtask

  task automatic t_stall();
    do_reset();
    beta_i[0] = 8'sd2;
    repeat (5) pulse(2'b01, 2'b00);
    repeat (3) tick();
    pulse(2'b01, 2'b00);
    chk(!switch_o && phase_o == 0, "R7 change restarts", phase_o, 0);
    run_phase(5, 1, "R7 stall after change");
  endtask

  task automatic t_sequence_walk();
    do_reset();
    lmin_i = 8'd2; lmax_i = 8'd3; walk_i = 8'd3;
    ped_req_i = 1; @(negedge clk); ped_req_i = 0;
    run_phase(1, 1, "R6 zero queue");
    run_phase(2, 2, "R8 yellow to left");
    chk(arm_o == 0, "R8 left same arm", arm_o, 0);
    run_phase(3, 1, "R9 left max");
    run_phase(2, 3, "R10 walk inserted");
    run_phase(3, 0, "R10 walk length");
    chk(arm_o == 1, "R10 arm toggles", arm_o, 1);
    run_phase(1, 1, "R8 second arm green");
    run_phase(2, 2, "R8 second arm left");
  endtask

  task automatic t_sequence_plain();
    do_reset();
    lmin_i = 8'd1; lmax_i = 8'd20;
    repeat (2) pulse(2'b01, 2'b00);
    gmax_i[0] = 8'd1;
    run_phase(1, 1, "R5 max one");
    run_phase(2, 2, "R8 yellow exact");
    run_phase(5, 1, "R9/R7 left stall");
    run_phase(2, 0, "R10 no request skips walk");
    chk(arm_o == 1, "R10 plain toggle", arm_o, 1);
  endtask

  initial begin
    #(5ns * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset_state();
    t_queue();
    t_min_hold();
    t_max_end();
    t_demand();
    t_stall();
    t_sequence_walk();
    t_sequence_plain();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule